// File: doc/BRIEF.md
# Block Data Word Engine

This engine moves 32-bit words between a host-side register interface and the word stream of a memory card data path, grouping them into blocks. The host first writes one configuration word that carries a block length in bytes and a block count. It then pulses a start with a direction (read from card or write to card) and a transfer type (single block or multi block). The engine tracks words left in the current block and blocks left in the transfer. It holds exactly one word in each direction and reports progress and faults in a five-bit status word.

On the write side the host offers words with a valid/ready pair. `host_wr_ready` is high only while a write transfer is running and the transmit holder is empty. The card side takes each word through `card_tx_valid`/`card_tx_ready`, and `card_tx_valid` with its data holds steady until it is taken. A card request (`card_tx_ready` high) while the holder is empty is an underrun. On the read side the card delivers words with `card_rx_valid` only; that port has no back-pressure. The host drains words with `host_rd_valid`/`host_rd_ready`. A card word that arrives while the previous word is still unread, and is not drained in the same cycle, is an overrun. Either fault is sticky until a status read, and it halts the transfer.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset the status word is all zero and `card_tx_valid` and `host_rd_valid` are low. Status bits are: bit 0 read word waiting, bit 1 write holder can accept, bit 2 overrun, bit 3 underrun, bit 4 transfer in progress.
- R2: The configuration word carries the block count in bits 15:0 and the block length in bytes in bits 31:16. The two low bits of the length are ignored, and words per block equal the masked length divided by four.
- R3: A multi-block transfer moves words-per-block times the programmed count. A single-block transfer moves exactly one block and ignores the count.
- R4: A start is ignored when the masked length gives zero words, or when the transfer is multi-block and the count is zero.
- R5: In a read transfer, a card word loads the read holder and raises `host_rd_valid` on the next cycle. A host handshake consumes the word and clears the flag.
- R6: In a write transfer, a host handshake loads the transmit holder, and the word is presented to the card on the next cycle in the order written. `card_tx_valid` and `card_tx_data` stay stable until `card_tx_ready`.
- R7: The in-progress bit rises on the cycle after an accepted start. It stays set until the final word of the final block is handled, which is the host consuming it (read) or the card taking it (write), and it clears on the following cycle.
- R8: The overrun bit is set when a card word arrives while the read holder is full and is not drained in that cycle.
- R9: The underrun bit is set when, during a write transfer, the card requests a word while the transmit holder is empty.
- R10: Overrun and underrun stay set until a `status_rd` pulse. A fault clears the in-progress bit, empties both holders, and no further words move.
- R11: Direction and word count are latched at start. A start, or a configuration write, while a transfer is in progress does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the block configuration word |
| cfg_wdata | input | 32 | Length [31:16], count [15:0] |
| start | input | 1 | Start pulse |
| start_rd | input | 1 | Direction at start: 1 read, 0 write |
| start_multi | input | 1 | Transfer type at start: 1 multi block, 0 single block |
| status_rd | input | 1 | Status read pulse, clears sticky faults |
| status | output | 5 | Status word (see R1) |
| host_wr_valid | input | 1 | Host offers a write word |
| host_wr_data | input | 32 | Host write word |
| host_wr_ready | output | 1 | Transmit holder can accept |
| host_rd_valid | output | 1 | Read word waiting |
| host_rd_data | output | 32 | Read word |
| host_rd_ready | input | 1 | Host consumes the read word |
| card_rx_valid | input | 1 | Card delivers a word (no back-pressure) |
| card_rx_data | input | 32 | Card received word |
| card_tx_valid | output | 1 | Word available for the card |
| card_tx_data | output | 32 | Word to the card |
| card_tx_ready | input | 1 | Card requests/takes a word |

## Verification
On every cycle the assertions check these properties: the block and word counters stay non-zero while a transfer runs; a read word is visible only during a read transfer; a word offered to the card is held until taken; faults stay set until a status read and always leave the engine idle; and the direction cannot change mid-transfer. Only the bench scenarios can show the rest: the exact number of words per transfer from the length mask and the count, data order, the ignored starts, and the cycle on which progress ends.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int ST_RX_RDY = 0;
  localparam int ST_TX_RDY = 1;
  localparam int ST_OVR    = 2;
  localparam int ST_UNR    = 3;
  localparam int ST_BUSY   = 4;
  localparam int ST_W      = 5;

  typedef enum logic { DIR_WRITE = 1'b0, DIR_READ = 1'b1 } dir_e;
endpackage

// File: rtl/bx_blk_cfg.sv
module bx_blk_cfg #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16,
  localparam int WPB_W = LEN_W - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [LEN_W+CNT_W-1:0]   cfg_wdata,
  output logic [WPB_W-1:0]         words_o,
  output logic [CNT_W-1:0]         count_o
);
  localparam logic [LEN_W-1:0] LEN_MASK = ~LEN_W'(3);

  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (cfg_we) begin
      len_q <= cfg_wdata[LEN_W+CNT_W-1:CNT_W];
      cnt_q <= cfg_wdata[CNT_W-1:0];
    end
  end

  // byte length forced down to whole words
  assign eff_len = len_q & LEN_MASK;
  assign words_o = WPB_W'(eff_len >> 2);
  assign count_o = cnt_q;
endmodule

// File: rtl/bx_word_counter.sv
module bx_word_counter #(
  parameter int WPB_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [WPB_W-1:0] load_words,
  input  logic [CNT_W-1:0] load_blocks,
  input  logic             step,
  output logic             final_o
);
  logic [WPB_W-1:0] wpb_q;
  logic [WPB_W-1:0] word_left_q;
  logic [CNT_W-1:0] blk_left_q;
  logic             last_in_blk;

  assign last_in_blk = (word_left_q == WPB_W'(1));
  assign final_o     = last_in_blk && (blk_left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpb_q       <= '0;
      word_left_q <= '0;
      blk_left_q  <= '0;
    end else if (load) begin
      wpb_q       <= load_words;
      word_left_q <= load_words;
      blk_left_q  <= load_blocks;
    end else if (step) begin
      if (last_in_blk) begin
        if (blk_left_q != CNT_W'(1)) begin
          blk_left_q  <= blk_left_q - CNT_W'(1);
          word_left_q <= wpb_q;
        end
      end else begin
        word_left_q <= word_left_q - WPB_W'(1);
      end
    end
  end

  // R3: a running transfer always has work left in both counters
  a_r3_counts_live: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (word_left_q != '0) && (blk_left_q != '0));
endmodule

// File: rtl/bx_word_hold.sv
module bx_word_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (flush) begin
      full_o <= 1'b0;
    end else if (load) begin
      full_o <= 1'b1;
      data_o <= load_data;
    end else if (take) begin
      full_o <= 1'b0;
    end
  end

  // R5: an unflushed load always leaves a word waiting
  a_r5_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    load && !flush |=> full_o);
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
  import blkxfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  localparam int WPB_W = LEN_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [LEN_W+CNT_W-1:0] cfg_wdata,
  input  logic                   start,
  input  logic                   start_rd,
  input  logic                   start_multi,
  input  logic                   status_rd,
  output logic [ST_W-1:0]        status,
  input  logic                   host_wr_valid,
  input  logic [DATA_W-1:0]      host_wr_data,
  output logic                   host_wr_ready,
  output logic                   host_rd_valid,
  output logic [DATA_W-1:0]      host_rd_data,
  input  logic                   host_rd_ready,
  input  logic                   card_rx_valid,
  input  logic [DATA_W-1:0]      card_rx_data,
  output logic                   card_tx_valid,
  output logic [DATA_W-1:0]      card_tx_data,
  input  logic                   card_tx_ready
);
  logic [WPB_W-1:0] cfg_words;
  logic [CNT_W-1:0] cfg_count;
  logic [CNT_W-1:0] blocks_load;

  logic busy_q, ovr_q, unr_q;
  dir_e dir_q;

  logic start_ok, active_rd, active_wr;
  logic rx_full, tx_full, rx_take, rx_arrive, rx_load, tx_load, tx_take;
  logic ovr_evt, unr_evt, fault, step, final_word, done, flush;

  bx_blk_cfg #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .words_o(cfg_words), .count_o(cfg_count)
  );

  assign blocks_load = start_multi ? cfg_count : CNT_W'(1);
  assign start_ok    = start && !busy_q && (cfg_words != '0) && (blocks_load != '0);

  assign active_rd = busy_q && (dir_q == DIR_READ);
  assign active_wr = busy_q && (dir_q == DIR_WRITE);

  // read path: card pushes, host drains
  assign rx_take   = host_rd_ready && rx_full;
  assign rx_arrive = card_rx_valid && active_rd;
  assign ovr_evt   = rx_arrive && rx_full && !rx_take;
  assign rx_load   = rx_arrive && !ovr_evt;

  // write path: host fills, card drains
  assign host_wr_ready = active_wr && !tx_full;
  assign tx_load       = host_wr_valid && host_wr_ready;
  assign card_tx_valid = active_wr && tx_full;
  assign tx_take       = card_tx_valid && card_tx_ready;
  assign unr_evt       = active_wr && card_tx_ready && !tx_full;

  assign fault = ovr_evt || unr_evt;
  assign step  = (active_rd && rx_take) || tx_take;
  assign done  = step && final_word;
  assign flush = start_ok || fault || done;

  bx_word_hold #(.DATA_W(DATA_W)) u_rx_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(rx_load),
    .load_data(card_rx_data), .take(rx_take),
    .full_o(rx_full), .data_o(host_rd_data)
  );

  bx_word_hold #(.DATA_W(DATA_W)) u_tx_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(tx_load),
    .load_data(host_wr_data), .take(tx_take),
    .full_o(tx_full), .data_o(card_tx_data)
  );

  bx_word_counter #(.WPB_W(WPB_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .load(start_ok),
    .load_words(cfg_words), .load_blocks(blocks_load),
    .step(step), .final_o(final_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_WRITE;
      ovr_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      if (start_ok) begin
        busy_q <= 1'b1;
        dir_q  <= start_rd ? DIR_READ : DIR_WRITE;
      end else if (fault || done) begin
        busy_q <= 1'b0;
      end
      if (ovr_evt)        ovr_q <= 1'b1;
      else if (status_rd) ovr_q <= 1'b0;
      if (unr_evt)        unr_q <= 1'b1;
      else if (status_rd) unr_q <= 1'b0;
    end
  end

  assign host_rd_valid      = rx_full;
  assign status[ST_RX_RDY]  = rx_full;
  assign status[ST_TX_RDY]  = host_wr_ready;
  assign status[ST_OVR]     = ovr_q;
  assign status[ST_UNR]     = unr_q;
  assign status[ST_BUSY]    = busy_q;

  // R5: a read word is only ever visible during a read transfer
  a_r5_rd_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_valid |-> busy_q && (dir_q == DIR_READ));

  // R6: word offered to the card holds until taken
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid && !card_tx_ready |=> card_tx_valid && $stable(card_tx_data));

  // R10: faults are sticky until a status read
  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !status_rd |=> ovr_q);
  a_r10_unr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unr_q && !status_rd |=> unr_q);

  // R10: a fresh fault leaves the engine idle and empty
  a_r10_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) || $rose(unr_q) |-> !busy_q && !rx_full && !tx_full);

  // R11: direction cannot change while a transfer runs
  a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(dir_q));
endmodule

// File: tb/blkxfer_engine_tb.sv
module blkxfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0, start_rd = 1'b0, start_multi = 1'b0, status_rd = 1'b0;
  logic [4:0]  status;
  logic        host_wr_valid = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        host_wr_ready;
  logic        host_rd_valid;
  logic [31:0] host_rd_data;
  logic        host_rd_ready = 1'b0;
  logic        card_rx_valid = 1'b0;
  logic [31:0] card_rx_data = '0;
  logic        card_tx_valid;
  logic [31:0] card_tx_data;
  logic        card_tx_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  blkxfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .start_rd(start_rd), .start_multi(start_multi),
    .status_rd(status_rd), .status(status),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .host_rd_valid(host_rd_valid),
    .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
    .card_tx_ready(card_tx_ready)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] cnt;
    logic        rd;
    logic        multi;
    logic [15:0] exp_words;
  } vec_t;

  // len, count, read, multi, expected words (length masked to words)
  localparam vec_t VEC [6] = '{
    '{16'h0010, 16'd3, 1'b0, 1'b1, 16'd12},
    '{16'h0010, 16'd3, 1'b1, 1'b1, 16'd12},
    '{16'h000B, 16'd5, 1'b0, 1'b0, 16'd2},
    '{16'h0006, 16'd2, 1'b1, 1'b1, 16'd2},
    '{16'h0008, 16'd1, 1'b1, 1'b1, 16'd2},
    '{16'h0004, 16'd4, 1'b0, 1'b1, 16'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_xfer(input logic [15:0] len, input logic [15:0] cnt,
                            input logic rd, input logic multi);
    cfg_we = 1'b1; cfg_wdata = {len, cnt};
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b1; start_rd = rd; start_multi = multi;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] d, input string tag);
    check({tag, " R6 wr ready"}, 32'(host_wr_ready), 32'd1);
    host_wr_valid = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_valid = 1'b0;
    check({tag, " R6 card valid"}, 32'(card_tx_valid), 32'd1);
    check({tag, " R6 card data"}, card_tx_data, d);
    card_tx_ready = 1'b1;
    @(negedge clk);
    card_tx_ready = 1'b0;
  endtask

  task automatic read_word(input logic [31:0] d, input string tag);
    card_rx_valid = 1'b1; card_rx_data = d;
    @(negedge clk);
    card_rx_valid = 1'b0;
    check({tag, " R5 rd valid"}, 32'(host_rd_valid), 32'd1);
    check({tag, " R5 rd data"}, host_rd_data, d);
    host_rd_ready = 1'b1;
    @(negedge clk);
    host_rd_ready = 1'b0;
  endtask

  task automatic pulse_status_rd();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 status after reset", 32'(status), 32'd0);
    check("R1 card valid after reset", 32'(card_tx_valid), 32'd0);
    check("R1 rd valid after reset", 32'(host_rd_valid), 32'd0);

    // R2 R3 R7: table of transfers
    for (int v = 0; v < 6; v++) begin
      start_xfer(VEC[v].len, VEC[v].cnt, VEC[v].rd, VEC[v].multi);
      check("R7 busy after start", 32'(status[4]), 32'd1);
      n = 0;
      while (status[4] && n < 64) begin
        if (VEC[v].rd) read_word({16'(v), 16'(n)} ^ 32'hA5A5_0000, "vec");
        else           write_word({16'(v), 16'(n)} ^ 32'h5A5A_0000, "vec");
        n++;
      end
      check("R2 R3 words moved", 32'(n), 32'(VEC[v].exp_words));
      check("R7 idle status after last word", 32'(status), 32'd0);
    end

    // R4: zero words or zero count ignored
    start_xfer(16'h0003, 16'd1, 1'b0, 1'b0);
    check("R4 zero-length start ignored", 32'(status), 32'd0);
    start_xfer(16'h0008, 16'd0, 1'b1, 1'b1);
    check("R4 zero-count multi start ignored", 32'(status), 32'd0);

    // R11: start and config write while busy change nothing
    start_xfer(16'h0008, 16'd1, 1'b0, 1'b0);
    start_xfer(16'h0040, 16'd9, 1'b1, 1'b1);
    check("R11 still write busy", 32'(status), 32'b10010);
    n = 0;
    while (status[4] && n < 64) begin
      write_word(32'hC0DE_0000 + 32'(n), "R11");
      n++;
    end
    check("R11 latched word count", 32'(n), 32'd2);

    // R8 R10: overrun
    start_xfer(16'h0008, 16'd1, 1'b1, 1'b0);
    card_rx_valid = 1'b1; card_rx_data = 32'h1111_1111;
    @(negedge clk);
    card_rx_data = 32'h2222_2222;
    @(negedge clk);
    card_rx_valid = 1'b0;
    check("R8 overrun halts", 32'(status), 32'b00100);
    card_rx_valid = 1'b1;
    @(negedge clk);
    card_rx_valid = 1'b0;
    @(negedge clk);
    check("R10 overrun sticky, no word", 32'(status), 32'b00100);
    check("R10 no read word after fault", 32'(host_rd_valid), 32'd0);
    pulse_status_rd();
    check("R10 status read clears overrun", 32'(status), 32'd0);

    // R9 R10: underrun
    start_xfer(16'h0008, 16'd1, 1'b0, 1'b0);
    card_tx_ready = 1'b1;
    @(negedge clk);
    card_tx_ready = 1'b0;
    check("R9 underrun halts", 32'(status), 32'b01000);
    check("R10 no card word after fault", 32'(card_tx_valid), 32'd0);
    @(negedge clk);
    check("R10 underrun sticky", 32'(status), 32'b01000);
    pulse_status_rd();
    check("R10 status read clears underrun", 32'(status), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule